// File: doc/BRIEF.md
# Console Device Register Page

This block claims the top page of a 16-bit processor's address space and presents five device registers in it: a keyboard status word, a keyboard data word, a display status word, a display data word and a machine control word. When the processor reads or writes one of these words, the block decodes the address and answers. Its page-hit output tells the memory system to keep the access away from ordinary storage.

Ready flags sit in the top bit of the two status words. The data registers change them as a side effect. A character arriving from the keyboard side raises the keyboard flag, and reading the keyboard data word drops it. A write to the display data word sends the low byte out with a one-cycle strobe and drops the display flag. A completion pulse from the display raises the flag again. The top bit of the control word drives a clock-enable output, and clearing that bit stops instruction processing.

Reads are combinational: the read data is valid in the same cycle as the address and read enable. All side effects take place at the clock edge that ends the access.

Top module: `conio_regs`

## Requirements
- R1: `devHit` is 1 in the same cycle whenever `busAddr` lies in 0xFE00..0xFFFF, and 0 for every lower address.
- R2: A read of 0xFE00 returns the keyboard ready flag in bit 15 and zeros in bits 14..0.
- R3: A `kbdStrobe` cycle raises the keyboard ready flag and replaces the stored character with `kbdByte`. Each later strobe overwrites the character. A read of 0xFE02 returns the character in bits 7..0 and zeros above.
- R4: A read of 0xFE02 clears the keyboard ready flag at the closing edge. If `kbdStrobe` is high in the same cycle, the flag stays set.
- R5: A read of 0xFE04 returns the display ready flag in bit 15 and zeros in bits 14..0.
- R6: A write to 0xFE06 clears the display ready flag at the closing edge. In the following cycle it drives `dispStrobe` high for exactly one cycle, with `dispByte` equal to the written bits 7..0. `dispDone` sets the flag, but a display write in the same cycle takes priority and leaves it clear.
- R7: A write to 0xFFFE stores all 16 bits, and a read of 0xFFFE returns them. `clkEnable` follows bit 15 of the stored word from the next cycle.
- R8: Reads of any other address, including the write-only 0xFE06, return 0x0000. Reads without `busRe`, and reads outside the page, also return 0x0000. Writes to the status words or to unassigned page addresses change no register.
- R9: After reset the display flag is 1, the keyboard flag is 0, the control word is 0x8000 (so `clkEnable` is 1), the stored character is 0x00 and `dispStrobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Processor address |
| busWdata | input | 16 | Processor write data |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable |
| busRdata | output | 16 | Read data, combinational |
| devHit | output | 1 | Address lies in the device page |
| kbdStrobe | input | 1 | A new keyboard character is present |
| kbdByte | input | 8 | The new keyboard character |
| dispByte | output | 8 | Character sent to the display |
| dispStrobe | output | 1 | One-cycle pulse marking a new display character |
| dispDone | input | 1 | The display has finished the last character |
| clkEnable | output | 1 | Instruction processing runs while this is 1 |

## Verification
Read data and `devHit` are due in the cycle the address is presented, so the bench checks them shortly after it drives inputs on the falling edge. Flag changes and control-word updates take effect at the next rising edge. The bench therefore checks them with a read one cycle after the causing access. `dispStrobe` and `dispByte` are registered, so they are checked at the falling edge right after the write edge, and again one cycle later to confirm the pulse has ended. The same-cycle collisions (keyboard strobe with a data read, display write with completion) each get a directed test.

// File: rtl/conio_pkg.sv
package conio_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_CTRL
  } rdSel_e;

  typedef struct packed {
    logic   kbdDataRd;
    logic   dispDataWr;
    logic   ctrlWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/conio_ctrl.sv
module conio_ctrl
  import conio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_BASE  = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFE
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output logic              devHit,
  output ctrlStrobe_t       strb
);

  always_comb begin
    devHit = (busAddr >= PAGE_BASE);

    strb.kbdDataRd  = busRe && (busAddr == KDATA_ADDR);
    strb.dispDataWr = busWe && (busAddr == DDATA_ADDR);
    strb.ctrlWr     = busWe && (busAddr == CTRL_ADDR);

    strb.rdSel = SEL_NONE;
    if (busRe) begin
      if      (busAddr == KSTAT_ADDR) strb.rdSel = SEL_KSTAT;
      else if (busAddr == KDATA_ADDR) strb.rdSel = SEL_KDATA;
      else if (busAddr == DSTAT_ADDR) strb.rdSel = SEL_DSTAT;
      else if (busAddr == CTRL_ADDR)  strb.rdSel = SEL_CTRL;
    end
  end

endmodule

// File: rtl/conio_dp.sv
module conio_dp
  import conio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [DATA_W-1:0] CTRL_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              kbdStrobe,
  input  logic [CHAR_W-1:0] kbdByte,
  input  logic              dispDone,
  output logic [CHAR_W-1:0] dispByte,
  output logic              dispStrobe,
  output logic              clkEnable,
  output logic              kbdReady,
  output logic              dispReady
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int PAD_W    = DATA_W - CHAR_W;

  logic [CHAR_W-1:0] kbdChar;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] kStatWord;
  logic [DATA_W-1:0] dStatWord;

  // Status words: flag in the top bit, every other bit tied low.
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_stat
      if (gi == FLAG_BIT) begin : g_flag
        assign kStatWord[gi] = kbdReady;
        assign dStatWord[gi] = dispReady;
      end else begin : g_zero
        assign kStatWord[gi] = 1'b0;
        assign dStatWord[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbdReady <= 1'b0;
      kbdChar  <= '0;
    end else if (kbdStrobe) begin
      kbdReady <= 1'b1;
      kbdChar  <= kbdByte;
    end else if (strb.kbdDataRd) begin
      kbdReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispReady  <= 1'b1;
      dispStrobe <= 1'b0;
      dispByte   <= '0;
    end else begin
      dispStrobe <= strb.dispDataWr;
      if (strb.dispDataWr) begin
        dispReady <= 1'b0;
        dispByte  <= busWdata[CHAR_W-1:0];
      end else if (dispDone) begin
        dispReady <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           ctrlWord <= CTRL_RESET;
    else if (strb.ctrlWr) ctrlWord <= busWdata;
  end

  assign clkEnable = ctrlWord[FLAG_BIT];

  always_comb begin
    unique case (strb.rdSel)
      SEL_KSTAT: busRdata = kStatWord;
      SEL_KDATA: busRdata = {{PAD_W{1'b0}}, kbdChar};
      SEL_DSTAT: busRdata = dStatWord;
      SEL_CTRL:  busRdata = ctrlWord;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/conio_regs.sv
module conio_regs
  import conio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_BASE  = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              devHit,
  input  logic              kbdStrobe,
  input  logic [CHAR_W-1:0] kbdByte,
  output logic [CHAR_W-1:0] dispByte,
  output logic              dispStrobe,
  input  logic              dispDone,
  output logic              clkEnable
);

  localparam logic [DATA_W-1:0] CTRL_RESET = {1'b1, {(DATA_W-1){1'b0}}};

  ctrlStrobe_t strb;
  logic        kbdReady;
  logic        dispReady;

  conio_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE),
    .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
    .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWe(busWe),
    .busRe(busRe),
    .devHit(devHit),
    .strb(strb)
  );

  conio_dp #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .CTRL_RESET(CTRL_RESET)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .strb(strb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .kbdStrobe(kbdStrobe),
    .kbdByte(kbdByte),
    .dispDone(dispDone),
    .dispByte(dispByte),
    .dispStrobe(dispStrobe),
    .clkEnable(clkEnable),
    .kbdReady(kbdReady),
    .dispReady(dispReady)
  );

endmodule

// File: rtl/conio_regs_chk.sv
module conio_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_BASE  = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic              devHit,
  input logic              kbdStrobe,
  input logic              dispStrobe,
  input logic              dispDone,
  input logic              clkEnable,
  input logic              kbdReady,
  input logic              dispReady
);

  p_page_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    devHit == (busAddr >= PAGE_BASE));

  p_kbd_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kbdStrobe |=> kbdReady);

  p_kbd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busRe && busAddr == KDATA_ADDR && !kbdStrobe) |=> !kbdReady);

  p_disp_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == DDATA_ADDR) |=> (dispStrobe && !dispReady));

  p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dispStrobe |-> $past(busWe && busAddr == DDATA_ADDR));

  p_disp_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dispDone && !(busWe && busAddr == DDATA_ADDR)) |=> dispReady);

  p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == CTRL_ADDR) |=> (clkEnable == $past(busWdata[DATA_W-1])));

  p_quiet_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!devHit || !busRe) |-> (busRdata == '0));

endmodule

bind conio_regs conio_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BASE(PAGE_BASE),
  .KDATA_ADDR(KDATA_ADDR), .DDATA_ADDR(DDATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
  .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .devHit(devHit),
  .kbdStrobe(kbdStrobe), .dispStrobe(dispStrobe), .dispDone(dispDone),
  .clkEnable(clkEnable), .kbdReady(kbdReady), .dispReady(dispReady)
);

// File: tb/conio_regs_test.sv
module conio_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [15:0] busRdata;
  logic        devHit;
  logic        kbdStrobe = 1'b0;
  logic [7:0]  kbdByte = '0;
  logic [7:0]  dispByte;
  logic        dispStrobe;
  logic        dispDone = 1'b0;
  logic        clkEnable;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  conio_regs uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .devHit(devHit),
    .kbdStrobe(kbdStrobe), .kbdByte(kbdByte), .dispByte(dispByte),
    .dispStrobe(dispStrobe), .dispDone(dispDone), .clkEnable(clkEnable)
  );

  // op: 0 read, 1 write, 2 keyboard char (data[7:0]), 3 display done
  // fields {op[1:0], addr[15:0], data[15:0], expected[15:0], req[3:0]}
  localparam int NV = 24;
  localparam logic [53:0] VEC [NV] = '{
    {2'd0, 16'hFE00, 16'h0000, 16'h0000, 4'd9},  // R9 keyboard not ready
    {2'd0, 16'hFE04, 16'h0000, 16'h8000, 4'd9},  // R9 display ready
    {2'd0, 16'hFFFE, 16'h0000, 16'h8000, 4'd9},  // R9 control word
    {2'd2, 16'h0000, 16'h0041, 16'h0000, 4'd3},  // R3 char arrives
    {2'd0, 16'hFE00, 16'h0000, 16'h8000, 4'd2},  // R2 flag up
    {2'd0, 16'hFE02, 16'h0000, 16'h0041, 4'd3},  // R3 data read
    {2'd0, 16'hFE00, 16'h0000, 16'h0000, 4'd4},  // R4 flag cleared
    {2'd0, 16'hFE02, 16'h0000, 16'h0041, 4'd3},  // R3 char kept
    {2'd1, 16'hFE06, 16'h1234, 16'h0000, 4'd6},  // R6 display write
    {2'd0, 16'hFE04, 16'h0000, 16'h0000, 4'd5},  // R5 flag down
    {2'd3, 16'h0000, 16'h0000, 16'h0000, 4'd6},  // R6 done
    {2'd0, 16'hFE04, 16'h0000, 16'h8000, 4'd6},  // R6 flag up
    {2'd1, 16'hFE00, 16'hFFFF, 16'h0000, 4'd8},  // R8 write status ignored
    {2'd0, 16'hFE00, 16'h0000, 16'h0000, 4'd8},  // R8
    {2'd0, 16'hFE08, 16'h0000, 16'h0000, 4'd8},  // R8 unassigned
    {2'd0, 16'hFE06, 16'h0000, 16'h0000, 4'd8},  // R8 write-only
    {2'd0, 16'h1234, 16'h0000, 16'h0000, 4'd8},  // R8 outside page
    {2'd1, 16'hFFFE, 16'h0000, 16'h0000, 4'd7},  // R7 halt
    {2'd0, 16'hFFFE, 16'h0000, 16'h0000, 4'd7},  // R7
    {2'd1, 16'hFFFE, 16'h8005, 16'h0000, 4'd7},  // R7 resume
    {2'd0, 16'hFFFE, 16'h0000, 16'h8005, 4'd7},  // R7
    {2'd2, 16'h0000, 16'h007A, 16'h0000, 4'd3},  // R3
    {2'd2, 16'h0000, 16'h00C3, 16'h0000, 4'd3},  // R3 overwrite
    {2'd0, 16'hFE02, 16'h0000, 16'h00C3, 4'd3}   // R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    busWe = 1'b0; busRe = 1'b0; kbdStrobe = 1'b0; dispDone = 1'b0;
    busAddr = '0; busWdata = '0;
  endtask

  task automatic readAt(input logic [15:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    idle();
    busAddr = a; busRe = 1'b1;
    #1 check(req, busRdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++; nVec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 clkEnable", {15'd0, clkEnable}, 16'd1);
    check("R9 dispStrobe", {15'd0, dispStrobe}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VEC[i][53:52])
        2'd0: begin busAddr = VEC[i][51:36]; busRe = 1'b1; end
        2'd1: begin busAddr = VEC[i][51:36]; busWdata = VEC[i][35:20]; busWe = 1'b1; end
        2'd2: begin kbdStrobe = 1'b1; kbdByte = VEC[i][27:20]; end
        default: dispDone = 1'b1;
      endcase
      #1;
      if (VEC[i][53:52] == 2'd0)
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), busRdata, VEC[i][19:4]);
    end

    // R1 page decode
    @(negedge clk); idle(); busAddr = 16'hFDFF; #1 check("R1 FDFF", {15'd0, devHit}, 16'd0);
    busAddr = 16'hFE00; #1 check("R1 FE00", {15'd0, devHit}, 16'd1);
    busAddr = 16'hFFFF; #1 check("R1 FFFF", {15'd0, devHit}, 16'd1);
    busAddr = 16'h0000; #1 check("R1 0000", {15'd0, devHit}, 16'd0);

    // R6 strobe timing and byte
    @(negedge clk); idle(); busAddr = 16'hFE06; busWdata = 16'hAB57; busWe = 1'b1;
    #1 check("R6 no early strobe", {15'd0, dispStrobe}, 16'd0);
    @(negedge clk); idle();
    #1 check("R6 strobe high", {15'd0, dispStrobe}, 16'd1);
    check("R6 byte", {8'd0, dispByte}, 16'h0057);
    @(negedge clk);
    #1 check("R6 strobe one cycle", {15'd0, dispStrobe}, 16'd0);

    // R6 write wins over done in the same cycle
    @(negedge clk); idle(); dispDone = 1'b1; busAddr = 16'hFE06; busWdata = 16'h0033; busWe = 1'b1;
    readAt(16'hFE04, "R6 write beats done", 16'h0000);
    @(negedge clk); idle(); dispDone = 1'b1;
    readAt(16'hFE04, "R6 done sets ready", 16'h8000);

    // R4 new char wins over data read in the same cycle
    @(negedge clk); idle(); kbdStrobe = 1'b1; kbdByte = 8'h11; busAddr = 16'hFE02; busRe = 1'b1;
    readAt(16'hFE00, "R4 strobe beats read", 16'h8000);
    readAt(16'hFE02, "R3 new char", 16'h0011);

    // R7 clkEnable follows the control word
    @(negedge clk); idle(); busAddr = 16'hFFFE; busWdata = 16'h0000; busWe = 1'b1;
    @(negedge clk); idle();
    #1 check("R7 clkEnable low", {15'd0, clkEnable}, 16'd0);

    // R9 reset mid-run restores the initial state
    @(negedge clk); idle(); kbdStrobe = 1'b1; kbdByte = 8'h5A;
    @(negedge clk); idle(); busAddr = 16'hFE06; busWe = 1'b1;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 check("R9 clkEnable after reset", {15'd0, clkEnable}, 16'd1);
    readAt(16'hFE00, "R9 kbd flag", 16'h0000);
    readAt(16'hFE02, "R9 kbd char", 16'h0000);
    readAt(16'hFE04, "R9 disp flag", 16'h8000);
    readAt(16'hFFFE, "R9 control", 16'h8000);

    @(negedge clk); idle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule